// File: doc/BRIEF.md
# Watchdog Control Register with Write-Once Protection

This block is the bus-visible control register that configures a computer-operating-properly watchdog. It holds four settings that a separate watchdog core uses. The first is a window-mode enable. The second decides whether the watchdog halts while a background debugger is active. The third is a timeout-rate code. The last is a write-once lock that software cannot read. The register sits on a plain 8-bit register bus. A write happens on a clock edge when both select and write enable are high. Read data is combinational and always available.

Write permissions depend on the operating-mode input.

- **Special mode:** every field can be rewritten freely.
- **Normal mode:** the window bit and the rate field accept one write after reset. That write is used up even when the values it carries have no effect. The halt-in-background bit can only be set, never cleared.
- **Write-mask bit:** a write with the mask bit set leaves the window and rate settings untouched in either mode. It does not use up the single normal-mode write.

Top module: `wdg_ctrl_reg`

## Requirements
- R1: After reset, the window bit equals parameter RST_WIN, the rate field equals parameter RST_RATE, the halt-in-background bit is 0 and the write-once lock is open.
- R2: Read data is laid out as follows: bit 7 is the window bit, bit 6 is the halt-in-background bit, bits 5..3 always read 0, and bits 2..0 are the rate field (bits above RATE_W read 0).
- R3: In special mode, an unmasked write loads bit 7 into the window bit and bits RATE_W-1..0 into the rate field, including 0 and 000. This holds any number of times and does not touch the lock.
- R4: In normal mode, the first unmasked write after reset sets the window bit when wdata bit 7 is 1 and loads the rate field when the written rate is nonzero.
- R5: In normal mode, writing rate 000 leaves the rate unchanged but still closes the lock.
- R6: In normal mode, writing 0 to bit 7 leaves the window bit unchanged but still closes the lock.
- R7: In normal mode, once the lock is closed, further writes do not change the window bit or the rate field.
- R8: The halt-in-background bit (wdata bit 6) follows the written value in special mode. In normal mode a 1 sets it and a 0 is ignored. Masking does not affect this bit.
- R9: A write with wdata bit 3 set leaves the window bit and the rate field unchanged and does not close the lock.
- R10: No state changes unless select and write enable are both high at the clock edge.
- R11: Once closed, the lock opens again only through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| special_mode | input | 1 | 1 = unrestricted writes, 0 = normal-mode rules |
| sel | input | 1 | Register select |
| wr_en | input | 1 | Write enable, qualified by sel |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| win_mode | output | 1 | Window-mode enable to the watchdog core |
| stop_in_bg | output | 1 | Halt watchdog while background debug is active |
| rate | output | RATE_W | Timeout-rate code to the watchdog core |

## Verification
The lock is never visible on its own, so a wrong lock state shows up only on the first normal-mode write that depends on it. A lock that was never closed lets a second write change rdata one cycle later. A lock closed too early, by a masked write, blocks the first real write. A halt-in-background bit that clears wrongly appears on rdata bit 6 in the cycle after the offending normal-mode write. The bench therefore follows every write with an immediate read. It orders its writes so that each no-effect or masked write is followed by one whose outcome depends on the lock.

// File: rtl/wdg_ctrl_pkg.sv
package wdg_ctrl_pkg;
   // Bit positions that the read-back and write decode both rely on
   localparam int DATA_W     = 8;
   localparam int BIT_WIN    = 7;
   localparam int BIT_BG     = 6;
   localparam int BIT_MASK   = 3;
   localparam int RATE_MAX_W = 3;

   // Per-cycle update strobes from the decode to the field storage
   typedef struct packed {
      logic upd_win;
      logic win_nx;
      logic upd_bg;
      logic bg_nx;
      logic upd_rate;
      logic close_lock;
   } wdg_upd_t;
endpackage

// File: rtl/wdg_wr_decode.sv
module wdg_wr_decode
   import wdg_ctrl_pkg::*;
#(
   parameter int RATE_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 special_mode,
   input  logic                 sel,
   input  logic                 wr_en,
   input  logic [DATA_W-1:0]    wdata,
   input  logic                 locked,
   output wdg_upd_t             upd,
   output logic [RATE_W-1:0]    rate_nx
);
   logic wr_hit;
   logic masked;
   logic open_wr;
   logic rate_nz;
   logic unused_bits;

   assign wr_hit      = sel && wr_en;
   assign masked      = wdata[BIT_MASK];
   assign rate_nx     = wdata[RATE_W-1:0];
   assign rate_nz     = |wdata[RATE_W-1:0];
   assign open_wr     = wr_hit && !masked && !locked;
   assign unused_bits = ^wdata[5:RATE_W];

   always_comb begin
      upd = '0;
      if (special_mode) begin
         upd.upd_bg   = wr_hit;
         upd.bg_nx    = wdata[BIT_BG];
         upd.upd_win  = wr_hit && !masked;
         upd.win_nx   = wdata[BIT_WIN];
         upd.upd_rate = wr_hit && !masked;
      end else begin
         upd.upd_bg     = wr_hit && wdata[BIT_BG];
         upd.bg_nx      = 1'b1;
         upd.upd_win    = open_wr && wdata[BIT_WIN];
         upd.win_nx     = 1'b1;
         upd.upd_rate   = open_wr && rate_nz;
         upd.close_lock = open_wr;
      end
   end

   // R9: a masked write must never request a lock close
   p_mask_no_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && masked) |-> !upd.close_lock);
   // R10: without a bus write no strobe may fire
   p_no_strobe_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |-> (!upd.upd_win && !upd.upd_bg && !upd.upd_rate && !upd.close_lock));
endmodule

// File: rtl/wdg_field_regs.sv
module wdg_field_regs
   import wdg_ctrl_pkg::*;
#(
   parameter int          RATE_W   = 3,
   parameter bit          RST_WIN  = 1'b0,
   parameter int unsigned RST_RATE = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              special_mode,
   input  wdg_upd_t          upd,
   input  logic [RATE_W-1:0] rate_nx,
   output logic              win_q,
   output logic              bg_q,
   output logic [RATE_W-1:0] rate_q,
   output logic              locked_q
);
   localparam logic [RATE_W-1:0] RATE_INIT = RATE_W'(RST_RATE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q    <= RST_WIN;
         bg_q     <= 1'b0;
         rate_q   <= RATE_INIT;
         locked_q <= 1'b0;
      end else begin
         if (upd.upd_win)    win_q    <= upd.win_nx;
         if (upd.upd_bg)     bg_q     <= upd.bg_nx;
         if (upd.upd_rate)   rate_q   <= rate_nx;
         if (upd.close_lock) locked_q <= 1'b1;
      end
   end

   // R11: lock stays closed until reset
   p_lock_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      locked_q |=> locked_q);
   // R7: closed lock in normal mode freezes window and rate
   p_locked_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (locked_q && !special_mode) |=> ($stable(win_q) && $stable(rate_q)));
   // R8: normal mode never clears the background bit
   p_bg_no_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bg_q && !special_mode) |=> bg_q);
   // R6: normal mode never clears the window bit
   p_win_no_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (win_q && !special_mode) |=> win_q);
endmodule

// File: rtl/wdg_ctrl_reg.sv
module wdg_ctrl_reg
   import wdg_ctrl_pkg::*;
#(
   parameter int          RATE_W   = 3,
   parameter bit          RST_WIN  = 1'b0,
   parameter int unsigned RST_RATE = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              special_mode,
   input  logic              sel,
   input  logic              wr_en,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic              win_mode,
   output logic              stop_in_bg,
   output logic [RATE_W-1:0] rate
);
   if (RATE_W < 1 || RATE_W > RATE_MAX_W) begin : g_bad_rate_w
      $error("wdg_ctrl_reg: RATE_W must be 1..3");
   end
   if (RST_RATE >= (1 << RATE_W)) begin : g_bad_rst_rate
      $error("wdg_ctrl_reg: RST_RATE does not fit RATE_W");
   end

   wdg_upd_t          upd;
   logic [RATE_W-1:0] rate_nx;
   logic              locked;

   wdg_wr_decode #(.RATE_W(RATE_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
      .sel(sel), .wr_en(wr_en), .wdata(wdata), .locked(locked),
      .upd(upd), .rate_nx(rate_nx)
   );

   wdg_field_regs #(.RATE_W(RATE_W), .RST_WIN(RST_WIN), .RST_RATE(RST_RATE)) u_regs (
      .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
      .upd(upd), .rate_nx(rate_nx),
      .win_q(win_mode), .bg_q(stop_in_bg), .rate_q(rate), .locked_q(locked)
   );

   // Read-back assembly: fixed positions for window and background bits,
   // rate bits packed at the bottom, everything else zero
   for (genvar i = 0; i < DATA_W; i++) begin : g_rd
      if (i == BIT_WIN) begin : g_win
         assign rdata[i] = win_mode;
      end else if (i == BIT_BG) begin : g_bg
         assign rdata[i] = stop_in_bg;
      end else if (i < RATE_W) begin : g_rate
         assign rdata[i] = rate[i];
      end else begin : g_zero
         assign rdata[i] = 1'b0;
      end
   end

   // R2: unimplemented read bits stay zero
   p_zero_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[5:3] == 3'b000);
   // R10: idle bus leaves all visible state untouched
   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel && wr_en) |=> $stable(rdata));
   // R9: masked write keeps window and rate
   p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && wr_en && wdata[BIT_MASK]) |=> ($stable(win_mode) && $stable(rate)));
endmodule

// File: tb/wdg_ctrl_reg_tb.sv
module wdg_ctrl_reg_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       special_mode = 1'b0;
   logic       sel = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       win_mode;
   logic       stop_in_bg;
   logic [2:0] rate;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   wdg_ctrl_reg #(.RATE_W(3), .RST_WIN(1'b0), .RST_RATE(7)) u_dut (
      .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
      .sel(sel), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
      .win_mode(win_mode), .stop_in_bg(stop_in_bg), .rate(rate)
   );

   // Entry: {special, wdata, expected rdata, requirement number}
   localparam int NV = 10;
   localparam logic [24:0] VEC [NV] = '{
      {1'b0, 8'h8D, 8'h07, 8'd9},  // R9 masked normal write: no change
      {1'b0, 8'h48, 8'h47, 8'd9},  // R9 masked write still sets bg (R8)
      {1'b0, 8'h80, 8'hC7, 8'd5},  // R4/R5 win set, rate 000 kept, lock closes
      {1'b0, 8'h82, 8'hC7, 8'd7},  // R7 second normal write ignored
      {1'b0, 8'h00, 8'hC7, 8'd8},  // R8 normal mode cannot clear bg
      {1'b1, 8'h03, 8'h03, 8'd3},  // R3 special write, bg cleared (R8)
      {1'b1, 8'h00, 8'h00, 8'd3},  // R3 special write of zeros
      {1'b1, 8'hB6, 8'h86, 8'd2},  // R2 bits 5..4 written high read 0
      {1'b1, 8'h49, 8'hC6, 8'd9},  // R9 masked special write
      {1'b0, 8'h05, 8'hC6, 8'd11}  // R11 lock still closed after special writes
   };

   task automatic check(input logic [7:0] exp, input int req, input string what);
      total++;
      if (rdata !== exp) begin
         bad++;
         $display("FAIL R%0d %s: rdata=%02h expected=%02h", req, what, rdata, exp);
      end
   endtask

   task automatic bus_write(input logic spec, input logic [7:0] d);
      @(negedge clk);
      special_mode = spec;
      sel = 1'b1;
      wr_en = 1'b1;
      wdata = d;
      @(negedge clk);
      sel = 1'b0;
      wr_en = 1'b0;
      special_mode = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (2000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: run did not end");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      do_reset();
      check(8'h07, 1, "reset value");
      total++;
      if ({win_mode, stop_in_bg, rate} !== 5'b0_0_111) begin
         bad++;
         $display("FAIL R1 output pins: %b expected 00111", {win_mode, stop_in_bg, rate});
      end

      for (int i = 0; i < NV; i++) begin
         bus_write(VEC[i][24], VEC[i][23:16]);
         check(VEC[i][15:8], int'(VEC[i][7:0]), "vector");
      end

      // R1: reset reopens everything
      do_reset();
      check(8'h07, 1, "second reset");

      // R10: select without enable, and enable without select
      @(negedge clk);
      sel = 1'b1; wr_en = 1'b0; wdata = 8'hFF;
      @(negedge clk);
      sel = 1'b0; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      check(8'h07, 10, "no write strobe");

      // R6/R4: win 0 ignored, rate loaded, lock closes
      bus_write(1'b0, 8'h05);
      check(8'h05, 6, "win 0 no effect");
      bus_write(1'b0, 8'h80);
      check(8'h05, 6, "win-0 write consumed lock");

      // R11: lock opens only through reset
      do_reset();
      bus_write(1'b0, 8'h02);
      check(8'h02, 11, "lock reopened by reset");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule